// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It watches the register specifiers, write enables and load flags of the instructions sitting in decode, execute, memory and writeback. From these it picks where each execute-stage operand comes from, and where each branch-compare operand in decode comes from. It also decides when the front of the pipeline must wait and when the fetched instruction must be thrown away.

ALU results are bypassed into the next instruction's execute stage without delay. A load followed directly by a consumer costs one bubble. Branches are compared in decode while fetch carries on down the fall-through path. When a branch resolves taken, the single instruction already fetched is turned into a nop. A branch that needs a value still being produced waits: one cycle behind an ALU op, two behind a load.

The block's outputs are combinational, so they take effect in the cycle the inputs show. The clock and reset feed only the embedded checks.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: An execute-stage operand whose register (nonzero) matches the memory-stage destination of a writing non-load gets select 2 (memory-stage bypass), with no stall.
- R2: An execute-stage operand that matches only the writeback-stage destination of a writing instruction gets select 1 (writeback bypass); with no match the select is 0 (register file).
- R3: When both the memory-stage and the writeback-stage destinations match an operand, select 2 (the younger value) wins.
- R4: Register 0 is never bypassed (select 0) and never causes a stall, whatever the stage destinations are.
- R5: A decode instruction that reads a register written by a load in execute raises pc_hold_o, ifid_hold_o and idex_bubble_o together for one cycle. Once the load has moved on to memory, a non-branch consumer no longer stalls, and in the following cycle it takes the load value through select 1.
- R6: With one unrelated instruction between a load and its consumer (the load in memory, the consumer in decode), no stall is raised.
- R7: A branch in decode whose operand is written by any instruction in execute stalls. It also stalls if that operand is written by a load in memory. When the value is available from a memory-stage ALU op, the decode select is 2; when it is available from writeback, the decode select is 1.
- R8: A branch in decode that resolves taken and is not stalled raises ifid_squash_o. A branch that is not taken, or that is stalled, leaves ifid_squash_o low.
- R9: With no dependence between stages, every hold, bubble and squash output is 0 and all selects are 0.
- R10: A decode operand whose use flag is 0 never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_rs1_i | input | REG_AW | Decode source register 1 |
| id_rs2_i | input | REG_AW | Decode source register 2 |
| id_use_rs1_i | input | 1 | Decode reads source 1 |
| id_use_rs2_i | input | 1 | Decode reads source 2 |
| id_branch_i | input | 1 | Decode holds a conditional branch |
| id_taken_i | input | 1 | Branch compare result from decode |
| ex_rs1_i | input | REG_AW | Execute source register 1 |
| ex_rs2_i | input | REG_AW | Execute source register 2 |
| ex_rd_i | input | REG_AW | Execute destination register |
| ex_we_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | REG_AW | Memory-stage destination register |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | REG_AW | Writeback destination register |
| wb_we_i | input | 1 | Writeback instruction writes a register |
| ex_fwd_a_o | output | 2 | Execute operand 1 source: 0 file, 1 writeback, 2 memory |
| ex_fwd_b_o | output | 2 | Execute operand 2 source, same code |
| id_fwd_a_o | output | 2 | Branch-compare operand 1 source, same code |
| id_fwd_b_o | output | 2 | Branch-compare operand 2 source, same code |
| pc_hold_o | output | 1 | Keep the program counter |
| ifid_hold_o | output | 1 | Keep the fetch/decode register |
| idex_bubble_o | output | 1 | Load a nop with writes cleared into execute |
| ifid_squash_o | output | 1 | Turn the fetched instruction into a nop |

## Verification
The two functions that can fall in the same cycle are the branch squash and a stall. A taken branch in decode whose operand is still being produced in execute, or by a load in memory, is made to resolve taken while the stall is active. The bench expects the holds and the bubble to be high and the squash to stay low in that cycle. Short stage-by-stage walks then advance the producer. In the cycle the dependence clears, the bench expects the squash and the correct decode bypass select to appear together.

// File: rtl/pipe_hz_pkg.sv
package pipe_hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_WB  = 2'd1,
    FWD_MEM = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import pipe_hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] rs_i,
  input  logic              use_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              mem_ld_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output logic [1:0]        sel_o
);
  logic rs_live;
  logic hit_mem, hit_wb;

  assign rs_live = use_i && (rs_i != '0);
  // load data is not ready in MEM; only ALU results bypass from there
  assign hit_mem = rs_live && mem_we_i && !mem_ld_i && (mem_rd_i == rs_i);
  assign hit_wb  = rs_live && wb_we_i && (wb_rd_i == rs_i);

  always_comb begin
    sel_o = FWD_RF;
    if (hit_mem)     sel_o = FWD_MEM;
    else if (hit_wb) sel_o = FWD_WB;
  end

  assert_r0_no_fwd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_i == '0) |-> (sel_o == FWD_RF));
  assert_mem_src_alu_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == FWD_MEM) |-> (mem_we_i && !mem_ld_i && mem_rd_i == rs_i));
  assert_wb_src_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == FWD_WB) |-> (wb_we_i && wb_rd_i == rs_i));
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit #(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_use_rs1_i,
  input  logic              id_use_rs2_i,
  input  logic              id_branch_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              mem_load_i,
  output logic              stall_o
);
  logic ex_dst_live, mem_ld_live;
  logic id_reads_ex, id_reads_mem;
  logic load_use, branch_wait;

  assign ex_dst_live = ex_we_i && (ex_rd_i != '0);
  assign mem_ld_live = mem_we_i && mem_load_i && (mem_rd_i != '0);

  assign id_reads_ex  = (id_use_rs1_i && id_rs1_i == ex_rd_i) ||
                        (id_use_rs2_i && id_rs2_i == ex_rd_i);
  assign id_reads_mem = (id_use_rs1_i && id_rs1_i == mem_rd_i) ||
                        (id_use_rs2_i && id_rs2_i == mem_rd_i);

  assign load_use    = ex_dst_live && ex_load_i && id_reads_ex;
  // compare sits in ID: wait on any EX producer, and on a load still in MEM
  assign branch_wait = id_branch_i &&
                       ((ex_dst_live && id_reads_ex) || (mem_ld_live && id_reads_mem));
  assign stall_o     = load_use || branch_wait;

  assert_unused_ops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!id_use_rs1_i && !id_use_rs2_i) |-> !stall_o);
  assert_nonbranch_only_ld_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !id_branch_i) |-> (ex_load_i && ex_we_i));
  assert_r0_no_stall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_rd_i == '0 && mem_rd_i == '0) |-> !stall_o);
endmodule

// File: rtl/hz_flow_ctrl.sv
module hz_flow_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stall_i,
  input  logic id_branch_i,
  input  logic id_taken_i,
  output logic pc_hold_o,
  output logic ifid_hold_o,
  output logic idex_bubble_o,
  output logic ifid_squash_o
);
  assign pc_hold_o     = stall_i;
  assign ifid_hold_o   = stall_i;
  assign idex_bubble_o = stall_i;
  // a stalled branch has not resolved yet; never squash under a hold
  assign ifid_squash_o = id_branch_i && id_taken_i && !stall_i;

  assert_squash_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifid_squash_o |-> (!pc_hold_o && !ifid_hold_o && id_branch_i && id_taken_i));
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_use_rs1_i,
  input  logic              id_use_rs2_i,
  input  logic              id_branch_i,
  input  logic              id_taken_i,
  input  logic [REG_AW-1:0] ex_rs1_i,
  input  logic [REG_AW-1:0] ex_rs2_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_we_i,
  input  logic              ex_load_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              mem_load_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  output logic [1:0]        ex_fwd_a_o,
  output logic [1:0]        ex_fwd_b_o,
  output logic [1:0]        id_fwd_a_o,
  output logic [1:0]        id_fwd_b_o,
  output logic              pc_hold_o,
  output logic              ifid_hold_o,
  output logic              idex_bubble_o,
  output logic              ifid_squash_o
);
  localparam int NOPS = 4;

  logic [REG_AW-1:0] op_rs  [NOPS];
  logic              op_use [NOPS];
  logic [1:0]        op_sel [NOPS];
  logic              stall;

  assign op_rs[0] = ex_rs1_i;  assign op_use[0] = 1'b1;
  assign op_rs[1] = ex_rs2_i;  assign op_use[1] = 1'b1;
  assign op_rs[2] = id_rs1_i;  assign op_use[2] = id_use_rs1_i;
  assign op_rs[3] = id_rs2_i;  assign op_use[3] = id_use_rs2_i;

  for (genvar i = 0; i < NOPS; i++) begin : g_op
    hz_fwd_sel #(.REG_AW(REG_AW)) u_sel (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rs_i    (op_rs[i]),
      .use_i   (op_use[i]),
      .mem_rd_i(mem_rd_i),
      .mem_we_i(mem_we_i),
      .mem_ld_i(mem_load_i),
      .wb_rd_i (wb_rd_i),
      .wb_we_i (wb_we_i),
      .sel_o   (op_sel[i])
    );
  end

  assign ex_fwd_a_o = op_sel[0];
  assign ex_fwd_b_o = op_sel[1];
  assign id_fwd_a_o = op_sel[2];
  assign id_fwd_b_o = op_sel[3];

  hz_stall_unit #(.REG_AW(REG_AW)) u_stall (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .id_rs1_i    (id_rs1_i),
    .id_rs2_i    (id_rs2_i),
    .id_use_rs1_i(id_use_rs1_i),
    .id_use_rs2_i(id_use_rs2_i),
    .id_branch_i (id_branch_i),
    .ex_rd_i     (ex_rd_i),
    .ex_we_i     (ex_we_i),
    .ex_load_i   (ex_load_i),
    .mem_rd_i    (mem_rd_i),
    .mem_we_i    (mem_we_i),
    .mem_load_i  (mem_load_i),
    .stall_o     (stall)
  );

  hz_flow_ctrl u_flow (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stall_i      (stall),
    .id_branch_i  (id_branch_i),
    .id_taken_i   (id_taken_i),
    .pc_hold_o    (pc_hold_o),
    .ifid_hold_o  (ifid_hold_o),
    .idex_bubble_o(idex_bubble_o),
    .ifid_squash_o(ifid_squash_o)
  );

  assert_hold_bubble_same_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({pc_hold_o, ifid_hold_o, idex_bubble_o}) == 0) ||
    ($countones({pc_hold_o, ifid_hold_o, idex_bubble_o}) == 3));
  assert_no_mem_fwd_of_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_load_i |-> (ex_fwd_a_o != FWD_MEM && ex_fwd_b_o != FWD_MEM &&
                    id_fwd_a_o != FWD_MEM && id_fwd_b_o != FWD_MEM));
endmodule

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
  localparam int AW = 5;

  typedef struct packed {
    logic [7:0]    req;
    logic [AW-1:0] id_rs1, id_rs2;
    logic          id_u1, id_u2, id_br, id_tk;
    logic [AW-1:0] ex_rs1, ex_rs2, ex_rd;
    logic          ex_we, ex_ld;
    logic [AW-1:0] mem_rd;
    logic          mem_we, mem_ld;
    logic [AW-1:0] wb_rd;
    logic          wb_we;
    logic [1:0]    e_exa, e_exb, e_ida, e_idb;
    logic          e_stall, e_sq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R9 idle
    '{8'd9, 5'd0,5'd0,1'b0,1'b0,1'b0,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,2'd0,2'd0,1'b0,1'b0},
    // R1 ALU result in MEM -> operand a
    '{8'd1, 5'd0,5'd0,1'b0,1'b0,1'b0,1'b0, 5'd3,5'd4,5'd0,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd0,1'b0, 2'd2,2'd0,2'd0,2'd0,1'b0,1'b0},
    // R2 WB match -> operand b
    '{8'd2, 5'd0,5'd0,1'b0,1'b0,1'b0,1'b0, 5'd1,5'd5,5'd0,1'b0,1'b0, 5'd9,1'b1,1'b0, 5'd5,1'b1, 2'd0,2'd1,2'd0,2'd0,1'b0,1'b0},
    // R3 both match, younger wins
    '{8'd3, 5'd0,5'd0,1'b0,1'b0,1'b0,1'b0, 5'd6,5'd6,5'd0,1'b0,1'b0, 5'd6,1'b1,1'b0, 5'd6,1'b1, 2'd2,2'd2,2'd0,2'd0,1'b0,1'b0},
    // R4 register 0 everywhere
    '{8'd4, 5'd0,5'd0,1'b1,1'b1,1'b1,1'b0, 5'd0,5'd0,5'd0,1'b1,1'b1, 5'd0,1'b1,1'b0, 5'd0,1'b1, 2'd0,2'd0,2'd0,2'd0,1'b0,1'b0},
    // R5 load-use stall
    '{8'd5, 5'd2,5'd7,1'b1,1'b1,1'b0,1'b0, 5'd0,5'd0,5'd7,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,2'd0,2'd0,1'b1,1'b0},
    // R6 one instruction between load and consumer
    '{8'd6, 5'd7,5'd0,1'b1,1'b0,1'b0,1'b0, 5'd0,5'd0,5'd3,1'b1,1'b0, 5'd7,1'b1,1'b1, 5'd0,1'b0, 2'd0,2'd0,2'd0,2'd0,1'b0,1'b0},
    // R10 unused operand matches load
    '{8'd10,5'd9,5'd9,1'b0,1'b0,1'b0,1'b0, 5'd0,5'd0,5'd9,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,2'd0,2'd0,1'b0,1'b0},
    // R7 branch on ALU in EX, taken but stalled (R8 no squash)
    '{8'd7, 5'd10,5'd0,1'b1,1'b0,1'b1,1'b1, 5'd0,5'd0,5'd10,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,2'd0,2'd0,1'b1,1'b0},
    // R7 branch on load in MEM
    '{8'd7, 5'd0,5'd11,1'b0,1'b1,1'b1,1'b1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd11,1'b1,1'b1, 5'd0,1'b0, 2'd0,2'd0,2'd0,2'd0,1'b1,1'b0},
    // R7 branch on ALU in MEM, not taken
    '{8'd7, 5'd12,5'd0,1'b1,1'b0,1'b1,1'b0, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd12,1'b1,1'b0, 5'd0,1'b0, 2'd0,2'd0,2'd2,2'd0,1'b0,1'b0},
    // R7 branch on WB, taken -> squash
    '{8'd7, 5'd0,5'd13,1'b0,1'b1,1'b1,1'b1, 5'd0,5'd0,5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd13,1'b1, 2'd0,2'd0,2'd0,2'd1,1'b0,1'b1},
    // R8 independent branch taken
    '{8'd8, 5'd1,5'd2,1'b1,1'b1,1'b1,1'b1, 5'd0,5'd0,5'd3,1'b1,1'b0, 5'd4,1'b1,1'b0, 5'd5,1'b1, 2'd0,2'd0,2'd0,2'd0,1'b0,1'b1},
    // R8 independent branch not taken
    '{8'd8, 5'd1,5'd2,1'b1,1'b1,1'b1,1'b0, 5'd0,5'd0,5'd3,1'b1,1'b0, 5'd4,1'b1,1'b0, 5'd5,1'b1, 2'd0,2'd0,2'd0,2'd0,1'b0,1'b0},
    // R4 branch reads r0 while EX writes r0
    '{8'd4, 5'd0,5'd0,1'b1,1'b1,1'b1,1'b1, 5'd0,5'd0,5'd0,1'b1,1'b0, 5'd0,1'b1,1'b0, 5'd0,1'b1, 2'd0,2'd0,2'd0,2'd0,1'b0,1'b1}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] id_rs1_i, id_rs2_i, ex_rs1_i, ex_rs2_i, ex_rd_i, mem_rd_i, wb_rd_i;
  logic id_use_rs1_i, id_use_rs2_i, id_branch_i, id_taken_i;
  logic ex_we_i, ex_load_i, mem_we_i, mem_load_i, wb_we_i;
  logic [1:0] ex_fwd_a_o, ex_fwd_b_o, id_fwd_a_o, id_fwd_b_o;
  logic pc_hold_o, ifid_hold_o, idex_bubble_o, ifid_squash_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pipe_hazard_ctrl #(.REG_AW(AW)) u_pipe_hazard_ctrl (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk_i);
    id_rs1_i = v.id_rs1; id_rs2_i = v.id_rs2;
    id_use_rs1_i = v.id_u1; id_use_rs2_i = v.id_u2;
    id_branch_i = v.id_br; id_taken_i = v.id_tk;
    ex_rs1_i = v.ex_rs1; ex_rs2_i = v.ex_rs2; ex_rd_i = v.ex_rd;
    ex_we_i = v.ex_we; ex_load_i = v.ex_ld;
    mem_rd_i = v.mem_rd; mem_we_i = v.mem_we; mem_load_i = v.mem_ld;
    wb_rd_i = v.wb_rd; wb_we_i = v.wb_we;
    #2;
  endtask

  task automatic expect_all(input string req, input vec_t v);
    chk(req, "ex_fwd_a", int'(ex_fwd_a_o), int'(v.e_exa));
    chk(req, "ex_fwd_b", int'(ex_fwd_b_o), int'(v.e_exb));
    chk(req, "id_fwd_a", int'(id_fwd_a_o), int'(v.e_ida));
    chk(req, "id_fwd_b", int'(id_fwd_b_o), int'(v.e_idb));
    chk(req, "pc_hold", int'(pc_hold_o), int'(v.e_stall));
    chk(req, "ifid_hold", int'(ifid_hold_o), int'(v.e_stall));
    chk(req, "idex_bubble", int'(idex_bubble_o), int'(v.e_stall));
    chk(req, "squash", int'(ifid_squash_o), int'(v.e_sq));
  endtask

  function automatic vec_t blank();
    vec_t v;
    v = '0;
    return v;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t v;
    drive(blank());
    // R9 reset state: idle inputs give all-zero controls
    expect_all("R9", blank());
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      expect_all($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i]);
    end

    // R5 walk: load r7 in EX, consumer in ID
    v = blank(); v.id_rs1 = 5'd7; v.id_u1 = 1'b1;
    v.ex_rd = 5'd7; v.ex_we = 1'b1; v.ex_ld = 1'b1; v.e_stall = 1'b1;
    drive(v); expect_all("R5 walk stall", v);
    // bubble in EX, load in MEM: no second stall
    v = blank(); v.id_rs1 = 5'd7; v.id_u1 = 1'b1;
    v.mem_rd = 5'd7; v.mem_we = 1'b1; v.mem_ld = 1'b1;
    drive(v); expect_all("R5 walk release", v);
    // consumer in EX, load in WB: value arrives via writeback bypass
    v = blank(); v.ex_rs1 = 5'd7; v.wb_rd = 5'd7; v.wb_we = 1'b1; v.e_exa = 2'd1;
    drive(v); expect_all("R5 walk forward", v);

    // R7/R8 walk: ALU r4 in EX, taken branch on r4
    v = blank(); v.id_rs1 = 5'd4; v.id_u1 = 1'b1; v.id_br = 1'b1; v.id_tk = 1'b1;
    v.ex_rd = 5'd4; v.ex_we = 1'b1; v.e_stall = 1'b1;
    drive(v); expect_all("R7 alu-branch stall", v);
    v.ex_rd = 5'd0; v.ex_we = 1'b0; v.mem_rd = 5'd4; v.mem_we = 1'b1;
    v.e_stall = 1'b0; v.e_ida = 2'd2; v.e_sq = 1'b1;
    drive(v); expect_all("R8 alu-branch resolve", v);

    // R7 walk: load r6 feeding a taken branch, two stall cycles
    v = blank(); v.id_rs2 = 5'd6; v.id_u2 = 1'b1; v.id_br = 1'b1; v.id_tk = 1'b1;
    v.ex_rd = 5'd6; v.ex_we = 1'b1; v.ex_ld = 1'b1; v.e_stall = 1'b1;
    drive(v); expect_all("R7 load-branch stall1", v);
    v.ex_rd = 5'd0; v.ex_we = 1'b0; v.ex_ld = 1'b0;
    v.mem_rd = 5'd6; v.mem_we = 1'b1; v.mem_ld = 1'b1;
    drive(v); expect_all("R7 load-branch stall2", v);
    v.mem_rd = 5'd0; v.mem_we = 1'b0; v.mem_ld = 1'b0;
    v.wb_rd = 5'd6; v.wb_we = 1'b1;
    v.e_stall = 1'b0; v.e_idb = 2'd1; v.e_sq = 1'b1;
    drive(v); expect_all("R7 load-branch resolve", v);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule